// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Cell

Each interrupt source in a system gets one cell. The cells are linked in a line. The enable output of one cell feeds the enable input of the next, so the order of the wiring sets a fixed priority. The cell nearest the head of the line has the highest priority.

A cell records a one-cycle local service pulse as a pending flag. Once a cell holds a pending flag, it pulls the enable signal low for every cell below it. If its own enable input is high, it also pulls its active-low request output low. The request outputs of all cells are combined with AND into a single active-low line to the CPU.

The CPU acknowledges by driving an active-low acknowledge line low. On the falling edge of that line, the one pending cell whose enable input is high claims the cycle. From the next clock, that cell drives its 8-bit vector onto a shared bus. Each cell's output is zero when it is not driving, so the bus is the OR of all cell outputs. When the acknowledge line returns high, the serving cell drops its pending flag. On the next cycle its enable output follows its input again, and the next requester down the line can be seen.

The wrapper builds a line of N cells. Vector i is VEC_BASE + i*VEC_STEP, which gives 0x20, 0x24, 0x28 and 0x2C by default. There is no data stream at this block's edge, so every pin is a plain level signal and has no valid/ready handshake.

Top module: `irq_daisy_chain`

## Requirements
- R1: A one-cycle high pulse on dev_req_i[i] sets a pending flag in cell i. If that cell is enabled, irq_n_o is low from the next clock edge onward.
- R2: While no cell holds a pending flag, chain_en_o equals chain_en_i.
- R3: A pending cell drives its enable output low, which disables every cell after it. chain_en_o is low whenever irq_n_o is low.
- R4: One clock after ack_n_i falls, vec_oe_o is high and vec_o carries the vector of the enabled pending cell with the lowest index. Cell i's vector is VEC_BASE + i*VEC_STEP. vec_oe_o is never high while ack_n_i is high.
- R5: At most one cell drives the vector bus at any time.
- R6: While chain_en_i is low, pending flags are kept, but irq_n_o stays high and an acknowledge causes no bus drive. Once chain_en_i goes high again, the pending requests are serviced.
- R7: While vec_oe_o is low, vec_o is zero.
- R8: The clock edge that sees ack_n_i high again clears the serving cell's pending flag and turns off its bus drive. The remaining requests are then serviced one per acknowledge, in order of increasing index, and after that irq_n_o and chain_en_o return high.
- R9: A request that arrives later at a cell nearer the head is serviced before an older pending request further down.
- R10: irq_n_o stays low while any enabled cell has a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chain_en_i | input | 1 | Enable into the head of the chain |
| dev_req_i | input | N | Local service pulse for each cell (index 0 is at the head) |
| ack_n_i | input | 1 | Active-low acknowledge from the CPU |
| irq_n_o | output | 1 | Active-low request line to the CPU, the AND of all cell request outputs |
| chain_en_o | output | 1 | Enable out of the tail of the chain |
| vec_o | output | VW | Shared vector bus, the OR of all cell outputs |
| vec_oe_o | output | 1 | High while some cell drives the vector bus |

## Verification
The bench goes through every non-empty set of simultaneous requests on four cells and services each set down to empty. This catches a priority encoder that is reversed or off by one: it would hand out a vector out of index order, or give the bus to two cells at once. Separate cases check three corner behaviours:
- A late request from a cell near the head must jump ahead of an older one. A design that serviced requests in arrival order would return the lower vector first.
- Requests made while the head enable is low must stay pending without raising the CPU line. A design that ignored the enable input would raise the line early, and a design that dropped the requests would leave nothing to service later.
- After release, the bus must read zero. A design that did not clear the pending flag on release would present the same vector again on the next acknowledge.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned VEC_W = 8;
  typedef logic [VEC_W-1:0] vec_t;

  function automatic vec_t vec_of(input vec_t base, input vec_t step, input int unsigned idx);
    vec_t r;
    r = base + vec_t'(idx) * step;
    return r;
  endfunction
endpackage

// File: rtl/irq_cell.sv
module irq_cell
  import irq_chain_pkg::*;
#(
  parameter vec_t VEC = 8'h20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ei_i,
  input  logic ack_n_i,
  input  logic ack_fall_i,
  output logic irq_n_o,
  output logic eo_o,
  output vec_t vec_o,
  output logic oe_o
);
  logic pending_q, serving_q;
  logic active, claim, release_now;

  assign active      = pending_q & ei_i;
  assign claim       = ack_fall_i & active & ~serving_q;
  assign release_now = serving_q & ack_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      serving_q <= 1'b0;
    end else begin
      pending_q <= (pending_q & ~release_now) | req_i;
      if (release_now)
        serving_q <= 1'b0;
      else if (claim)
        serving_q <= 1'b1;
    end
  end

  assign irq_n_o = ~active;
  assign eo_o    = ei_i & ~pending_q;
  assign oe_o    = serving_q & ~ack_n_i;
  assign vec_o   = oe_o ? VEC : '0;
endmodule

// File: rtl/irq_bus_or.sv
module irq_bus_or
  import irq_chain_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  vec_t [N-1:0] vec_i,
  output vec_t         vec_o
);
  vec_t acc [N+1];
  assign acc[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_or
    assign acc[i+1] = acc[i] | vec_i[i];
  end
  assign vec_o = acc[N];
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
  import irq_chain_pkg::*;
#(
  parameter int unsigned N        = 4,
  parameter int unsigned VW       = VEC_W,
  parameter vec_t        VEC_BASE = 8'h20,
  parameter vec_t        VEC_STEP = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chain_en_i,
  input  logic [N-1:0]  dev_req_i,
  input  logic          ack_n_i,
  output logic          irq_n_o,
  output logic          chain_en_o,
  output logic [VW-1:0] vec_o,
  output logic          vec_oe_o
);
  logic [N:0]   en_link;
  logic [N-1:0] cell_irq_n;
  logic [N-1:0] cell_oe;
  vec_t [N-1:0] cell_vec;
  vec_t         bus;
  logic         ack_q, ack_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b1;
    else        ack_q <= ack_n_i;
  end
  assign ack_fall = ack_q & ~ack_n_i;

  assign en_link[0] = chain_en_i;

  for (genvar i = 0; i < N; i++) begin : g_cell
    irq_cell #(.VEC(vec_of(VEC_BASE, VEC_STEP, i))) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (dev_req_i[i]),
      .ei_i      (en_link[i]),
      .ack_n_i   (ack_n_i),
      .ack_fall_i(ack_fall),
      .irq_n_o   (cell_irq_n[i]),
      .eo_o      (en_link[i+1]),
      .vec_o     (cell_vec[i]),
      .oe_o      (cell_oe[i])
    );
  end

  irq_bus_or #(.N(N)) u_bus (
    .vec_i(cell_vec),
    .vec_o(bus)
  );

  assign irq_n_o    = &cell_irq_n;
  assign chain_en_o = en_link[N];
  assign vec_o      = VW'(bus);
  assign vec_oe_o   = |cell_oe;
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chain_en_i,
  input logic          ack_n_i,
  input logic          irq_n_o,
  input logic          chain_en_o,
  input logic [VW-1:0] vec_o,
  input logic          vec_oe_o,
  input logic [N-1:0]  cell_oe
);
  AST_PASS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n_o && chain_en_i) |-> chain_en_o); // R2
  AST_TAIL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> !chain_en_o); // R3
  AST_DRIVE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe_o |-> !ack_n_i); // R4
  AST_DRIVE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_oe_o) |-> $past(!irq_n_o)); // R4
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_oe)); // R5
  AST_HEAD_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_en_i |-> irq_n_o); // R6
  AST_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_oe_o |-> (vec_o == '0)); // R7
endmodule

bind irq_daisy_chain irq_chain_chk #(.N(N), .VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chain_en_i(chain_en_i),
  .ack_n_i   (ack_n_i),
  .irq_n_o   (irq_n_o),
  .chain_en_o(chain_en_o),
  .vec_o     (vec_o),
  .vec_oe_o  (vec_oe_o),
  .cell_oe   (cell_oe)
);

// File: tb/irq_daisy_chain_test.sv
module irq_daisy_chain_test;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_en_i = 1'b1;
  logic [N-1:0] dev_req_i = '0;
  logic ack_n_i = 1'b1;
  logic irq_n_o, chain_en_o, vec_oe_o;
  logic [7:0] vec_o;
  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_daisy_chain uut (
    .clk(clk), .rst_n(rst_n), .chain_en_i(chain_en_i), .dev_req_i(dev_req_i),
    .ack_n_i(ack_n_i), .irq_n_o(irq_n_o), .chain_en_o(chain_en_o),
    .vec_o(vec_o), .vec_oe_o(vec_oe_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_vec(input int idx);
    return 8'h20 + idx * 4;
  endfunction

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk) dev_req_i = m;
    @(negedge clk) dev_req_i = '0;
  endtask

  // idx < 0 means no cell is expected to answer
  task automatic serve(input int idx);
    @(negedge clk) ack_n_i = 1'b0;
    @(negedge clk);
    chk("R4 oe during ack", int'(vec_oe_o), idx >= 0 ? 1 : 0);
    chk("R4 vector", int'(vec_o), idx >= 0 ? exp_vec(idx) : 0);
    ack_n_i = 1'b1;
    @(negedge clk);
    chk("R8 oe off after release", int'(vec_oe_o), 0);
    chk("R7 bus zero", int'(vec_o), 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset irq_n", int'(irq_n_o), 1);
    chk("reset oe", int'(vec_oe_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle pass-through", int'(chain_en_o), 1);
    chain_en_i = 1'b0;
    #1 chk("R2 idle pass-through low", int'(chain_en_o), 0);
    chain_en_i = 1'b1;

    // R1 R3 R5 R8 R10: every mask, serviced to empty in index order
    for (int m = 1; m < 16; m++) begin
      logic [N-1:0] rem;
      rem = m[N-1:0];
      pulse(rem);
      chk("R1 irq after pulse", int'(irq_n_o), 0);
      chk("R3 tail blocked", int'(chain_en_o), 0);
      while (rem != 0) begin
        int w;
        w = -1;
        for (int i = N - 1; i >= 0; i--) if (rem[i]) w = i;
        chk("R10 irq held while pending", int'(irq_n_o), 0);
        serve(w);
        rem[w] = 1'b0;
      end
      chk("R8 irq released", int'(irq_n_o), 1);
      chk("R8 chain restored", int'(chain_en_o), 1);
    end

    // R9: later head request preempts older lower one
    pulse(4'b0100);
    repeat (2) @(negedge clk);
    pulse(4'b0001);
    serve(0);
    serve(2);
    chk("R9 drained", int'(irq_n_o), 1);

    // R6: head disabled keeps requests but stays quiet
    chain_en_i = 1'b0;
    pulse(4'b1010);
    chk("R6 irq quiet", int'(irq_n_o), 1);
    chk("R6 tail low", int'(chain_en_o), 0);
    serve(-1);
    chain_en_i = 1'b1;
    #1 chk("R6 irq after enable", int'(irq_n_o), 0);
    serve(1);
    serve(3);
    chk("R6 drained", int'(irq_n_o), 1);
    chk("R6 chain restored", int'(chain_en_o), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule